// File: doc/BRIEF.md
# Dual DAC Register Update Controller

This block is the register front end for a pair of 12-bit digital-to-analog channels on an 8-bit register write bus. Each channel has a staged low byte and a staged high nibble. A shared control byte holds the data-width mode, a range flag per channel, a clear bit per channel, a power enable per channel and a synchronization bit. The controller decides when the staged values become the held output codes. It drives those codes, masked by the clear bits, together with the range and power flags, to the converters.

With the synchronization bit set, a write to a channel's low byte loads that channel's held code on the same clock edge. With the bit clear, writes only fill the staging registers. Both channels then load together on the edge that writes the bit back to 1. In byte mode, a single low-byte write fills the top eight bits of the code. In full-width mode, the high nibble supplies bits 11:8. Every register reads back one cycle after its read address is presented.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset, the control register reads 0x04. Both output codes, both range flags and both power flags are 0, and all staging registers read 0.
- R2: A control write takes effect after the write edge. Data bit 0 drives power flag 0 and bit 1 drives power flag 1. Bit 5 drives range flag 0 and bit 6 drives range flag 1.
- R3: Control bit 3 (channel 0) and bit 4 (channel 1) set the clear state. A 0 forces that channel's output code to 0. A 1 shows the held code, which is not lost while the channel is cleared.
- R4: While control bit 2 (sync) is 1, a write to a channel's low-byte register loads that channel's held code on the same edge. A write to a high-nibble register loads nothing.
- R5: While sync is 0, no data write changes either output code.
- R6: A control write that changes sync from 0 to 1 loads both channels' held codes from their staging registers on that write edge.
- R7: A control write with sync = 1 while sync is already 1 loads nothing.
- R8: With control bit 7 (mode) at 1, a loaded code is {low byte, 4'b0000}. For a sync-rising load, the mode is the bit 7 value in that same write.
- R9: With mode at 0, a loaded code is {high nibble, low byte}. Only data bits 3:0 of a high-nibble write are stored, and bits 7:4 read back as 0.
- R10: rd_data shows the register at rd_addr one cycle after it is sampled. The addresses are 0xFD for control, 0xF9/0xFA for the channel 0 low/high registers and 0xFB/0xFC for the channel 1 low/high registers. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Registered read data |
| dac0_code | output | 12 | Channel 0 output code |
| dac1_code | output | 12 | Channel 1 output code |
| dac_range_vdd | output | 2 | Per-channel range flag, 1 = supply range |
| dac_power_on | output | 2 | Per-channel power enable, 1 = on |

## Verification
A wrong held code stays hidden while its channel is cleared. The clear bits are therefore raised to expose it, and it then appears on the code output on the very next edge. Wrong staging contents show up only at the next load or the next read-back, so reads of every register are mixed into the stimulus. A bad sync edge detector shows up as codes that move one write too early, or not at all, after a control write. Each case is compared against a bench model right after the edge.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int DAC_BYTE_W = 8;
  localparam int DAC_NIB_W  = 4;
  localparam int DAC_CODE_W = DAC_BYTE_W + DAC_NIB_W;
  localparam int DAC_NUM_CH = 2;

  // control byte bit positions
  localparam int CB_MODE = 7;
  localparam int CB_RNG  = 5;  // + channel
  localparam int CB_CLR  = 3;  // + channel
  localparam int CB_SYNC = 2;
  localparam int CB_PD   = 0;  // + channel

  localparam logic [DAC_BYTE_W-1:0] CTRL_RESET = 8'h04;

  function automatic logic [DAC_CODE_W-1:0] dac_compose(
    input logic                  byte_mode,
    input logic [DAC_BYTE_W-1:0] lo,
    input logic [DAC_NIB_W-1:0]  hi
  );
    return byte_mode ? {lo, {DAC_NIB_W{1'b0}}} : {hi, lo};
  endfunction
endpackage

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg
  import dac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [DAC_BYTE_W-1:0] wdata,
  output logic [DAC_BYTE_W-1:0] ctrl_q,
  output logic                  sync_rise,
  output logic                  eff_mode
);
  logic [DAC_BYTE_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d    = ctrl_q;
    sync_rise = 1'b0;
    eff_mode  = ctrl_q[CB_MODE];
    if (we) begin
      ctrl_d    = wdata;
      sync_rise = wdata[CB_SYNC] & ~ctrl_q[CB_SYNC];
      eff_mode  = wdata[CB_MODE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_lo,
  input  logic                  we_hi,
  input  logic [DAC_BYTE_W-1:0] wdata,
  input  logic                  imm_sync,
  input  logic                  bulk_load,
  input  logic                  mode,
  input  logic                  clr_n,
  output logic [DAC_BYTE_W-1:0] lo_q,
  output logic [DAC_NIB_W-1:0]  hi_q,
  output logic [DAC_CODE_W-1:0] code
);
  logic [DAC_BYTE_W-1:0] lo_d;
  logic [DAC_NIB_W-1:0]  hi_d;
  logic [DAC_CODE_W-1:0] held_q, held_d;
  logic                  load;

  always_comb begin
    lo_d   = we_lo ? wdata : lo_q;
    hi_d   = we_hi ? wdata[DAC_NIB_W-1:0] : hi_q;
    load   = (we_lo & imm_sync) | bulk_load;
    held_d = load ? dac_compose(mode, lo_d, hi_q) : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      held_q <= '0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      held_q <= held_d;
    end
  end

  assign code = clr_n ? held_q : '0;
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_pkg::*;
#(
  parameter logic [7:0] ADDR_CTRL = 8'hFD,
  parameter logic [7:0] ADDR_LO0  = 8'hF9,
  parameter logic [7:0] ADDR_HI0  = 8'hFA,
  parameter logic [7:0] ADDR_LO1  = 8'hFB,
  parameter logic [7:0] ADDR_HI1  = 8'hFC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [DAC_BYTE_W-1:0] wr_data,
  input  logic [7:0]            rd_addr,
  output logic [DAC_BYTE_W-1:0] rd_data,
  output logic [DAC_CODE_W-1:0] dac0_code,
  output logic [DAC_CODE_W-1:0] dac1_code,
  output logic [DAC_NUM_CH-1:0] dac_range_vdd,
  output logic [DAC_NUM_CH-1:0] dac_power_on
);
  localparam logic [7:0] LO_ADDR [DAC_NUM_CH] = '{ADDR_LO0, ADDR_LO1};
  localparam logic [7:0] HI_ADDR [DAC_NUM_CH] = '{ADDR_HI0, ADDR_HI1};

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DAC_BYTE_W-1:0] ctrl_q;
  logic                  sync_rise, eff_mode, ctrl_we;
  logic [DAC_BYTE_W-1:0] lo_q   [DAC_NUM_CH];
  logic [DAC_NIB_W-1:0]  hi_q   [DAC_NUM_CH];
  logic [DAC_CODE_W-1:0] code_w [DAC_NUM_CH];

  assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);

  dac_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (ctrl_we),
    .wdata     (wr_data),
    .ctrl_q    (ctrl_q),
    .sync_rise (sync_rise),
    .eff_mode  (eff_mode)
  );

  for (genvar ch = 0; ch < DAC_NUM_CH; ch++) begin : g_ch
    logic we_lo, we_hi;
    assign we_lo = wr_en && (wr_addr == LO_ADDR[ch]);
    assign we_hi = wr_en && (wr_addr == HI_ADDR[ch]);

    dac_channel u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .we_lo     (we_lo),
      .we_hi     (we_hi),
      .wdata     (wr_data),
      .imm_sync  (ctrl_q[CB_SYNC]),
      .bulk_load (sync_rise),
      .mode      (eff_mode),
      .clr_n     (ctrl_q[CB_CLR+ch]),
      .lo_q      (lo_q[ch]),
      .hi_q      (hi_q[ch]),
      .code      (code_w[ch])
    );

    assign dac_range_vdd[ch] = ctrl_q[CB_RNG+ch];
    assign dac_power_on[ch]  = ctrl_q[CB_PD+ch];
  end

  assign dac0_code = code_w[0];
  assign dac1_code = code_w[1];

  // read path
  logic [DAC_BYTE_W-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (rd_addr == ADDR_CTRL) rd_d = ctrl_q;
    for (int ch = 0; ch < DAC_NUM_CH; ch++) begin
      if (rd_addr == LO_ADDR[ch]) rd_d = lo_q[ch];
      if (rd_addr == HI_ADDR[ch]) rd_d = {{(DAC_BYTE_W-DAC_NIB_W){1'b0}}, hi_q[ch]};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else             rd_data <= rd_d;
  end
endmodule

// File: rtl/dac_update_chk.sv
module dac_update_chk
  import dac_pkg::*;
#(
  parameter logic [7:0] ADDR_CTRL = 8'hFD,
  parameter logic [7:0] ADDR_LO0  = 8'hF9
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  wr_en,
  input logic [7:0]            wr_addr,
  input logic [DAC_BYTE_W-1:0] wr_data,
  input logic [7:0]            rd_addr,
  input logic [DAC_BYTE_W-1:0] rd_data,
  input logic [DAC_BYTE_W-1:0] ctrl_q,
  input logic [DAC_CODE_W-1:0] dac0_code,
  input logic [DAC_CODE_W-1:0] dac1_code,
  input logic [DAC_NUM_CH-1:0] dac_range_vdd,
  input logic [DAC_NUM_CH-1:0] dac_power_on
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  AST_CTRL_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_wr |=> (dac_power_on == $past(wr_data[1:0])) && (dac_range_vdd == $past(wr_data[6:5]))); // R2

  AST_CLEAR_CH0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_wr && !wr_data[CB_CLR]) |=> (dac0_code == '0)); // R3

  AST_CLEAR_CH1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_wr && !wr_data[CB_CLR+1]) |=> (dac1_code == '0)); // R3

  AST_HOLD_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_q[CB_SYNC] && !ctrl_wr) |=> ($stable(dac0_code) && $stable(dac1_code))); // R5

  AST_BYTE_MODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == ADDR_LO0 && ctrl_q[CB_MODE] && ctrl_q[CB_SYNC] && ctrl_q[CB_CLR])
      |=> (dac0_code == {$past(wr_data), {DAC_NIB_W{1'b0}}})); // R8

  AST_READ_CTRL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_addr == ADDR_CTRL && !ctrl_wr) |=> (rd_data == $past(ctrl_q))); // R10
endmodule

bind dac_update_ctrl dac_update_chk #(.ADDR_CTRL(ADDR_CTRL), .ADDR_LO0(ADDR_LO0)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .rd_addr       (rd_addr),
  .rd_data       (rd_data),
  .ctrl_q        (ctrl_q),
  .dac0_code     (dac0_code),
  .dac1_code     (dac1_code),
  .dac_range_vdd (dac_range_vdd),
  .dac_power_on  (dac_power_on)
);

// File: tb/dac_update_ctrl_test.sv
module dac_update_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] A_CTRL = 8'hFD, A_LO0 = 8'hF9, A_HI0 = 8'hFA,
                         A_LO1 = 8'hFB, A_HI1 = 8'hFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0]  rd_data;
  logic [11:0] dac0_code, dac1_code;
  logic [1:0]  dac_range_vdd, dac_power_on;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_update_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dac0_code(dac0_code), .dac1_code(dac1_code),
    .dac_range_vdd(dac_range_vdd), .dac_power_on(dac_power_on)
  );

  // bench model
  logic [7:0]  m_ctrl;
  logic [7:0]  m_lo [2];
  logic [3:0]  m_hi [2];
  logic [11:0] m_held [2];

  function automatic logic [11:0] mk_code(logic md, logic [7:0] lo, logic [3:0] hi);
    return md ? {lo, 4'h0} : {hi, lo};
  endfunction

  function automatic logic [11:0] exp_code(int ch);
    return m_ctrl[3+ch] ? m_held[ch] : 12'h000;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      A_CTRL:  return m_ctrl;
      A_LO0:   return m_lo[0];
      A_HI0:   return {4'h0, m_hi[0]};
      A_LO1:   return m_lo[1];
      A_HI1:   return {4'h0, m_hi[1]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    if (a == A_CTRL) begin
      if (d[2] && !m_ctrl[2])
        for (int c = 0; c < 2; c++) m_held[c] = mk_code(d[7], m_lo[c], m_hi[c]);
      m_ctrl = d;
    end else if (a == A_LO0 || a == A_LO1) begin
      int c = (a == A_LO0) ? 0 : 1;
      m_lo[c] = d;
      if (m_ctrl[2]) m_held[c] = mk_code(m_ctrl[7], d, m_hi[c]);
    end else if (a == A_HI0 || a == A_HI1) begin
      m_hi[(a == A_HI0) ? 0 : 1] = d[3:0];
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_outputs(string tag);
    check({tag, " code0"}, dac0_code, exp_code(0));
    check({tag, " code1"}, dac1_code, exp_code(1));
    check({tag, " range"}, dac_range_vdd, m_ctrl[6:5]);
    check({tag, " power"}, dac_power_on, m_ctrl[1:0]);
  endtask

  task automatic rd_check(logic [7:0] a, string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(tag, rd_data, exp_read(a));
  endtask

  initial begin
    m_ctrl = 8'h04;
    for (int c = 0; c < 2; c++) begin m_lo[c] = '0; m_hi[c] = '0; m_held[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 code0", dac0_code, 12'h000);
    check("R1 code1", dac1_code, 12'h000);
    check("R1 flags", {dac_range_vdd, dac_power_on}, 4'h0);
    rd_check(A_CTRL, "R1 ctrl read");
    rd_check(A_LO1, "R1 lo1 read");

    // R2 flag routing
    wr(A_CTRL, 8'h1F); check_outputs("R2 pd");
    check("R2 power literal", dac_power_on, 2'b11);
    wr(A_CTRL, 8'h7C); check_outputs("R2 rng");
    check("R2 range literal", dac_range_vdd, 2'b11);

    // R4 immediate load, R9 12-bit assembly
    wr(A_CTRL, 8'h1C);
    wr(A_HI0, 8'hA5); check("R4 hi write no load", dac0_code, 12'h000);
    wr(A_LO0, 8'h3C); check("R4 R9 lo load", dac0_code, 12'h53C);
    rd_check(A_HI0, "R9 hi upper nibble zero");

    // R3 clear keeps held code
    wr(A_CTRL, 8'h14); check("R3 cleared ch0", dac0_code, 12'h000);
    wr(A_CTRL, 8'h1C); check("R3 restored ch0", dac0_code, 12'h53C);

    // R5 staging only, R6 simultaneous load
    wr(A_CTRL, 8'h18);
    wr(A_LO0, 8'h11); wr(A_HI0, 8'h02); wr(A_LO1, 8'hEE); wr(A_HI1, 8'hFF);
    check("R5 ch0 held", dac0_code, 12'h53C);
    check("R5 ch1 held", dac1_code, 12'h000);
    wr(A_CTRL, 8'h1C);
    check("R6 ch0 loaded", dac0_code, 12'h211);
    check("R6 ch1 loaded", dac1_code, 12'hFEE);

    // R7 rewriting sync while set
    wr(A_HI0, 8'h07); wr(A_CTRL, 8'h1C);
    check("R7 no reload", dac0_code, 12'h211);

    // R8 byte mode, immediate and sync-rise
    wr(A_CTRL, 8'h9C); check("R7 mode change no load", dac0_code, 12'h211);
    wr(A_LO1, 8'hAB); check("R8 byte imm", dac1_code, 12'hAB0);
    wr(A_CTRL, 8'h18); wr(A_LO0, 8'h5A);
    wr(A_CTRL, 8'h9C);
    check("R8 byte bulk ch0", dac0_code, 12'h5A0);
    check("R8 byte bulk ch1", dac1_code, 12'hAB0);

    // R10 unmapped read
    rd_check(8'h00, "R10 unmapped");
    rd_check(A_LO0, "R10 lo0");

    // random mix (fixed seed)
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      int sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: a = A_CTRL;
        3, 4:    a = A_LO0;
        5:       a = A_HI0;
        6, 7:    a = A_LO1;
        8:       a = A_HI1;
        default: a = 8'hF8;
      endcase
      d = 8'($urandom);
      if (a == A_CTRL && $urandom_range(0, 2) != 0) d[4:3] = 2'b11;
      wr(a, d);
      check_outputs("R2 R3 R4 R5 R6 R7 R8 R9 random");
      if (i % 4 == 0) rd_check(8'($urandom_range(8'hF8, 8'hFE)), "R10 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule